// File: doc/BRIEF.md
# Highway and Farm-Road Intersection Light Controller

This block drives the lamps of a crossing where a busy highway meets a little-used farm road. The highway keeps a green light by default. A car sensor on the farm road asks for service, but the highway only gives way once it has held green for at least the long interval. The farm road then gets green for as long as a car is still seen, and never for longer than the long interval. Each change of green passes through a yellow phase that lasts the short interval.

Every phase is timed by one shared up-counter. The sequencer restarts it with a one-cycle start strobe whenever it leaves a phase. The counter saturates at the long threshold, so a long wait on the highway still counts as expired. The sensor input is assumed to be synchronous to the clock already. The start strobe is brought out as a port so that phase boundaries can be observed.

Top module: `farmroad_signal_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the highway shows green, the farm road shows red and the interval counter is zero. With a car present from release, highway green therefore lasts exactly LONG_CYCLES+1 cycles (13 with defaults).
- R2: In every cycle exactly one of green, yellow and red is high for each road, and at least one road shows red. The four legal patterns are highway green with farm red, highway yellow with farm red, farm green with highway red, and farm yellow with highway red.
- R3: Highway green is left only in a cycle where the counter has reached LONG_CYCLES and `car_present` is high; the next phase is highway yellow. A car seen earlier, or no car at all, keeps highway green.
- R4: Highway yellow lasts exactly SHORT_CYCLES+1 cycles (5 with defaults), whatever `car_present` does, and is followed by farm green.
- R5: Farm green is followed by farm yellow. It lasts LONG_CYCLES+1 cycles while a car stays present, and it ends in the cycle in which `car_present` is low, so a car leaving n cycles into the phase gives a length of n+1.
- R6: Farm yellow lasts exactly SHORT_CYCLES+1 cycles, whatever `car_present` does, and is followed by highway green.
- R7: `timer_start` is high in the final cycle of each phase and in no other cycle. In the cycle after it, the counter is zero.
- R8: The counter stops at LONG_CYCLES and stays there until it is restarted. A car that arrives long after the highway's minimum green has passed causes the strobe in the first cycle it is seen, so that highway green lasts (arrival offset + 1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_present | input | 1 | Farm-road car sensor, already synchronous |
| hwy_green | output | 1 | Highway green lamp |
| hwy_yellow | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_green | output | 1 | Farm-road green lamp |
| farm_yellow | output | 1 | Farm-road yellow lamp |
| farm_red | output | 1 | Farm-road red lamp |
| timer_start | output | 1 | One-cycle interval-timer restart strobe |

## Verification
The assertions check, on every cycle, that the lamp patterns are legal and that each phase exit follows from the timer flags and the sensor. They also check that the counter clears after a strobe, saturates and never exceeds its limit, and that no lamp moves without a strobe. What they cannot show is the length of each phase from the outside. The bench's scenarios show this: a sensor pulse during the minimum green, a car waiting past saturation, a car leaving partway through farm green, sensor toggling during yellow, and a reset in the middle of a phase, each compared with expected phase lengths that the bench computes from the two thresholds.

// File: rtl/farmroad_sig_pkg.sv
package farmroad_sig_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'd0,
        PH_HWY_WARN  = 2'd1,
        PH_FARM_GO   = 2'd2,
        PH_FARM_WARN = 2'd3
    } phase_e;

    typedef struct packed {
        logic go;
        logic warn;
        logic stop;
    } lamp_set_t;

    typedef struct packed {
        lamp_set_t hwy;
        lamp_set_t farm;
    } lamp_pair_t;

endpackage

// File: rtl/phase_interval_timer.sv
module phase_interval_timer #(
    parameter int SHORT_CYCLES = 4,
    parameter int LONG_CYCLES  = 12,
    parameter int CNT_W        = $clog2(LONG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic             short_done,
    output logic             long_done,
    output logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_CYCLES);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tmr_state_t;

    tmr_state_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.count = '0;
        end else if (tmr_q.count < LONG_C) begin
            tmr_d.count = tmr_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign short_done = (tmr_q.count >= SHORT_C);
    assign long_done  = (tmr_q.count >= LONG_C);
    assign elapsed    = tmr_q.count;

endmodule

// File: rtl/light_phase_seq.sv
module light_phase_seq
    import farmroad_sig_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car_present,
    input  logic   short_done,
    input  logic   long_done,
    output phase_e phase,
    output logic   phase_restart
);

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d         = seq_q;
        phase_restart = 1'b0;
        case (seq_q.phase)
            PH_HWY_GO: begin
                if (long_done && car_present) begin
                    seq_d.phase   = PH_HWY_WARN;
                    phase_restart = 1'b1;
                end
            end
            PH_HWY_WARN: begin
                if (short_done) begin
                    seq_d.phase   = PH_FARM_GO;
                    phase_restart = 1'b1;
                end
            end
            PH_FARM_GO: begin
                if (long_done || !car_present) begin
                    seq_d.phase   = PH_FARM_WARN;
                    phase_restart = 1'b1;
                end
            end
            PH_FARM_WARN: begin
                if (short_done) begin
                    seq_d.phase   = PH_HWY_GO;
                    phase_restart = 1'b1;
                end
            end
            default: begin
                seq_d.phase   = PH_HWY_GO;
                phase_restart = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.phase <= PH_HWY_GO;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.phase;

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
    import farmroad_sig_pkg::*;
(
    input  phase_e     phase,
    output lamp_pair_t lamps
);

    always_comb begin
        lamps = '0;
        case (phase)
            PH_HWY_GO: begin
                lamps.hwy.go    = 1'b1;
                lamps.farm.stop = 1'b1;
            end
            PH_HWY_WARN: begin
                lamps.hwy.warn  = 1'b1;
                lamps.farm.stop = 1'b1;
            end
            PH_FARM_GO: begin
                lamps.hwy.stop  = 1'b1;
                lamps.farm.go   = 1'b1;
            end
            default: begin
                lamps.hwy.stop  = 1'b1;
                lamps.farm.warn = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/farmroad_signal_ctrl.sv
module farmroad_signal_ctrl
    import farmroad_sig_pkg::*;
#(
    parameter int SHORT_CYCLES = 4,
    parameter int LONG_CYCLES  = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic car_present,
    output logic hwy_green,
    output logic hwy_yellow,
    output logic hwy_red,
    output logic farm_green,
    output logic farm_yellow,
    output logic farm_red,
    output logic timer_start
);

    localparam int CNT_W = $clog2(LONG_CYCLES + 1);

    logic             short_done;
    logic             long_done;
    logic [CNT_W-1:0] tmr_elapsed;
    phase_e           cur_phase;
    lamp_pair_t       lamps;

    phase_interval_timer #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES),
        .CNT_W        (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .restart    (timer_start),
        .short_done (short_done),
        .long_done  (long_done),
        .elapsed    (tmr_elapsed)
    );

    light_phase_seq seq_i (
        .clk           (clk),
        .rst           (rst),
        .car_present   (car_present),
        .short_done    (short_done),
        .long_done     (long_done),
        .phase         (cur_phase),
        .phase_restart (timer_start)
    );

    lamp_decode dec_i (
        .phase (cur_phase),
        .lamps (lamps)
    );

    assign hwy_green   = lamps.hwy.go;
    assign hwy_yellow  = lamps.hwy.warn;
    assign hwy_red     = lamps.hwy.stop;
    assign farm_green  = lamps.farm.go;
    assign farm_yellow = lamps.farm.warn;
    assign farm_red    = lamps.farm.stop;

endmodule

// File: rtl/farmroad_signal_ctrl_chk.sv
module farmroad_signal_ctrl_chk #(
    parameter int SHORT_CYCLES = 4,
    parameter int LONG_CYCLES  = 12,
    parameter int CNT_W        = $clog2(LONG_CYCLES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             car_present,
    input logic             hwy_green,
    input logic             hwy_yellow,
    input logic             hwy_red,
    input logic             farm_green,
    input logic             farm_yellow,
    input logic             farm_red,
    input logic             timer_start,
    input logic             short_done,
    input logic             long_done,
    input logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] LONG_C = CNT_W'(LONG_CYCLES);

    logic first_q;

    always_ff @(posedge clk) begin
        first_q <= rst;
    end

    p_home_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        first_q |-> (hwy_green && farm_red && elapsed == '0));

    p_lamp_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot({hwy_green, hwy_yellow, hwy_red}) &&
        $onehot({farm_green, farm_yellow, farm_red}) &&
        (hwy_red || farm_red));

    p_hwy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (hwy_green && !(car_present && long_done)) |=> hwy_green);

    p_hwy_leave_r3: assert property (@(posedge clk) disable iff (rst)
        (hwy_green && car_present && long_done) |=> hwy_yellow);

    p_hwy_warn_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (hwy_yellow && !short_done) |=> hwy_yellow);

    p_hwy_warn_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (hwy_yellow && short_done) |=> farm_green);

    p_farm_leave_r5: assert property (@(posedge clk) disable iff (rst)
        (farm_green && (!car_present || long_done)) |=> farm_yellow);

    p_farm_warn_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (farm_yellow && short_done) |=> hwy_green);

    p_strobe_clears_r7: assert property (@(posedge clk) disable iff (rst)
        timer_start |=> (elapsed == '0));

    p_no_strobe_no_move_r7: assert property (@(posedge clk) disable iff (rst)
        !timer_start |=> $stable({hwy_green, hwy_yellow, farm_green, farm_yellow}));

    p_count_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (!timer_start && long_done) |=> (long_done && $stable(elapsed)));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        elapsed <= LONG_C);

endmodule

bind farmroad_signal_ctrl farmroad_signal_ctrl_chk #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES),
    .CNT_W        (CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .car_present (car_present),
    .hwy_green   (hwy_green),
    .hwy_yellow  (hwy_yellow),
    .hwy_red     (hwy_red),
    .farm_green  (farm_green),
    .farm_yellow (farm_yellow),
    .farm_red    (farm_red),
    .timer_start (timer_start),
    .short_done  (short_done),
    .long_done   (long_done),
    .elapsed     (tmr_elapsed)
);

// File: tb/farmroad_signal_ctrl_tb_top.sv
`timescale 1ns/1ps
module farmroad_signal_ctrl_tb_top;

    localparam int SHORT_CYCLES = 4;
    localparam int LONG_CYCLES  = 12;
    localparam int YLEN = SHORT_CYCLES + 1;
    localparam int GLEN = LONG_CYCLES + 1;

    localparam int P_HG = 0;
    localparam int P_HY = 1;
    localparam int P_FG = 2;
    localparam int P_FY = 3;

    typedef struct {
        int    ph;
        int    len;
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_present = 1'b0;
    logic hwy_green, hwy_yellow, hwy_red;
    logic farm_green, farm_yellow, farm_red;
    logic timer_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_item_t exp_q[$];

    int cur_ph  = -1;
    int cur_len = 0;
    int st_cnt  = 0;
    int last_st = 0;

    always #2 clk = ~clk;

    farmroad_signal_ctrl #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .car_present (car_present),
        .hwy_green   (hwy_green),
        .hwy_yellow  (hwy_yellow),
        .hwy_red     (hwy_red),
        .farm_green  (farm_green),
        .farm_yellow (farm_yellow),
        .farm_red    (farm_red),
        .timer_start (timer_start)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int phase_of();
        if (hwy_green && !hwy_yellow && !hwy_red && farm_red && !farm_green && !farm_yellow) return P_HG;
        if (hwy_yellow && !hwy_green && !hwy_red && farm_red && !farm_green && !farm_yellow) return P_HY;
        if (farm_green && !farm_yellow && !farm_red && hwy_red && !hwy_green && !hwy_yellow) return P_FG;
        if (farm_yellow && !farm_green && !farm_red && hwy_red && !hwy_green && !hwy_yellow) return P_FY;
        return -1;
    endfunction

    task automatic expect_phase(int ph, int len, string tag);
        exp_item_t it;
        it.ph  = ph;
        it.len = len;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic close_phase();
        exp_item_t it;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected phase end (phase*1000+len)", cur_ph * 1000 + cur_len, -1);
        end else begin
            it = exp_q.pop_front();
            check((it.ph == cur_ph) && (it.len == cur_len), it.tag, "phase*1000+len",
                  cur_ph * 1000 + cur_len, it.ph * 1000 + it.len);
            check((st_cnt == 1) && (last_st == 1), "R7", "strobes in phase (last cycle *10)",
                  st_cnt + 10 * last_st, 11);
        end
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        int ph;
        if (rst) begin
            cur_ph = -1;
        end else begin
            ph = phase_of();
            check(ph >= 0, "R2", "legal lamp pattern", ph, 0);
            if (ph != cur_ph) begin
                if (cur_ph >= 0) close_phase();
                cur_ph  = ph;
                cur_len = 1;
                st_cnt  = int'(timer_start);
                last_st = int'(timer_start);
            end else begin
                cur_len++;
                st_cnt  += int'(timer_start);
                last_st = int'(timer_start);
            end
        end
    end

    task automatic wait_phase(int ph);
        do @(negedge clk); while (phase_of() != ph);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        // expected phase sequence for the main run
        expect_phase(P_HG, 31,   "R8");
        expect_phase(P_HY, YLEN, "R4");
        expect_phase(P_FG, GLEN, "R5");
        expect_phase(P_FY, YLEN, "R6");
        expect_phase(P_HG, GLEN, "R3");
        expect_phase(P_HY, YLEN, "R4");
        expect_phase(P_FG, 4,    "R5");
        expect_phase(P_FY, YLEN, "R6");
        expect_phase(P_HG, 21,   "R8");
        expect_phase(P_HY, YLEN, "R4");
        expect_phase(P_FG, GLEN, "R5");
        expect_phase(P_FY, YLEN, "R6");
        expect_phase(P_HG, GLEN, "R3");
        expect_phase(P_HY, YLEN, "R4");

        tick(3);
        rst = 1'b0;
        @(negedge clk);
        check(phase_of() == P_HG, "R1", "phase after reset", phase_of(), P_HG);
        check(timer_start == 1'b0, "R1", "strobe after reset", int'(timer_start), 0);

        // short sensor pulse inside the minimum green: ignored (R3)
        tick(3);
        car_present = 1'b1;
        tick(3);
        car_present = 1'b0;
        tick(14);
        @(negedge clk);
        check(hwy_green == 1'b1, "R3", "highway green with no car", int'(hwy_green), 1);
        check(timer_start == 1'b0, "R3", "no strobe with no car", int'(timer_start), 0);
        // car arrives long after saturation: immediate strobe (R8)
        tick(10);
        car_present = 1'b1;

        wait_phase(P_FG);
        wait_phase(P_FY);
        wait_phase(P_FG);
        // car leaves three cycles into farm green (R5)
        tick(3);
        car_present = 1'b0;

        wait_phase(P_HG);
        tick(20);
        car_present = 1'b1;

        // toggle the sensor during highway yellow: no effect (R4)
        wait_phase(P_HY);
        tick(1);
        car_present = 1'b0;
        tick(2);
        car_present = 1'b1;

        wait_phase(P_FY);
        wait_phase(P_HG);
        wait_phase(P_FG);

        // reset in the middle of farm green (R1)
        tick(4);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        expect_phase(P_HG, GLEN, "R1");
        expect_phase(P_HY, YLEN, "R4");
        @(negedge clk);
        check(phase_of() == P_HG, "R1", "phase after mid-run reset", phase_of(), P_HG);
        check(timer_start == 1'b0, "R1", "strobe after mid-run reset", int'(timer_start), 0);

        wait_phase(P_FG);
        @(posedge clk);
        check(exp_q.size() == 0, "R7", "outstanding expected phases", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule